// File: doc/BRIEF.md
# Operator-Pattern Memory Exerciser

This block drives a 16-bit buffer memory made of one or two equal modules with a single pattern word chosen by the operator. A start pulse latches the pattern and the module choice. The block then enters verify mode. In verify mode it writes the pattern into every word of the chosen module, reads every word back and compares each one with the pattern. It repeats this sweep until a word reads back wrong or the operator asks to leave. When a word reads back wrong, the block freezes and holds a report of the module, the address, the word it read and the word it expected.

While verify mode runs, an interrupt input moves the block into continuous mode, which is meant for probing the memory with test equipment. In write form it writes the pattern to consecutive addresses without pause. In read form it fills the module once and then reads without pause. The reads are still compared, and a wrong word sets a sticky flag instead of stopping the run. A separate exit input ends any run.

The memory port issues at most one access per cycle. Read data must be presented one cycle after the read request.

Top module: `pattern_exerciser`

## Requirements
- R1: On the clock edge that accepts `start` in idle mode, the block latches `pattern_in`, `module_sel` and `cfg_8k`. Later changes to those inputs do not alter the data written, the data expected or the module used until the next start.
- R2: When the latched `cfg_8k` is 0, every access goes to module 0 (`mem_mod` = 0) whatever `module_sel` is. When it is 1, every access goes to the latched `module_sel`.
- R3: A verify sweep first issues 2^ADDR_W writes, one per cycle, to addresses 0, 1, 2 and so on in ascending order. It then issues 2^ADDR_W reads in the same order, one per cycle. A read is `mem_en`=1 with `mem_we`=0, and its data is sampled on `mem_rdata` in the following cycle.
- R4: `pass_count` is cleared at start and rises by exactly 1 after each sweep with no mismatch. The first rise takes effect on the (2·2^ADDR_W+1)th edge after the edge that accepted start. Sweeps repeat with no end.
- R5: A verify mismatch puts `mode` into 3 (failed). The block then sets `err_valid` and holds the module, address, word read and pattern on the `err_*` outputs. It issues no further access and stays failed until `exit_req`.
- R6: `adv_int` seen while `mode` is 1 (verify) moves the block to `mode` 2 (continuous) on that edge, unless `exit_req` or a mismatch is present in the same cycle. `cont_write` is sampled on the same edge. `adv_int` has no effect in idle or failed mode.
- R7: In continuous write form (`cont_write`=1), the block writes the pattern every cycle, starting at address 0, in ascending order and wrapping from the last address to 0. It issues no read.
- R8: In continuous read form (`cont_write`=0), the block issues 2^ADDR_W writes starting at address 0, then reads every cycle in ascending order with wrap and no further writes. A read mismatch sets `cont_mismatch`, which stays set until the next start, and `mode` stays 2.
- R9: `exit_req` in any non-idle mode returns `mode` to 0 on that edge, and no access is issued while idle. The `err_*` outputs keep their values until the next start.
- R10: After reset, `mode` is 0, `mem_en` is 0, `pass_count` is 0, and `err_valid` and `cont_mismatch` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a verify run (taken in idle mode only) |
| pattern_in | input | DATA_W | Operator pattern |
| module_sel | input | 1 | Module choice, used only with cfg_8k=1 |
| cfg_8k | input | 1 | 1 when two modules are fitted |
| adv_int | input | 1 | Escalate from verify to continuous mode |
| cont_write | input | 1 | Continuous form: 1 write, 0 fill then read |
| exit_req | input | 1 | Leave the current run |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_mod | output | 1 | Module addressed |
| mem_addr | output | ADDR_W | Word address inside the module |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |
| mode | output | 2 | 0 idle, 1 verify, 2 continuous, 3 failed |
| pass_count | output | PASS_W | Completed clean verify sweeps |
| err_valid | output | 1 | A verify mismatch was recorded |
| err_module | output | 1 | Module of the mismatch |
| err_addr | output | ADDR_W | Address of the mismatch |
| err_actual | output | DATA_W | Word read back |
| err_expected | output | DATA_W | Pattern that was expected |
| cont_mismatch | output | 1 | Sticky continuous-read mismatch flag |

## Verification
Faults in the sweep counter show on `mem_addr` at once as a skipped or repeated address. A wrong phase register shows up as a read appearing before the N-th write, or as a write appearing in continuous read. Any of these is seen within one sweep, which is at most 2N+1 cycles. A fault in the compare path shows up in one of two ways within N+2 cycles of the faulty read. Either `pass_count` climbs past a word that reads back wrong, or the held `err_*` report names the wrong address or data. A lost latch of the pattern or module shows up as wrong memory contents, or as an access to the wrong module, during the first sweep.

// File: rtl/exr_pkg.sv
package exr_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_VERIFY = 2'd1,
        MODE_CONT   = 2'd2,
        MODE_FAIL   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        VP_WRITE = 2'd0,
        VP_READ  = 2'd1,
        VP_DRAIN = 2'd2
    } vphase_e;

    typedef enum logic [1:0] {
        CP_WRITE = 2'd0,
        CP_FILL  = 2'd1,
        CP_READ  = 2'd2
    } cphase_e;

    // Module actually used: a single-module build always targets module 0.
    function automatic logic pick_module(input logic two_modules, input logic sel);
        return two_modules & sel;
    endfunction

endpackage

// File: rtl/exr_addr_sweep.sv
module exr_addr_sweep #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
    end

    assign at_end = (addr == LAST);

    // R7: stepping past the last word lands on address 0
    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (step && !clr && at_end) |=> (addr == '0));

    // R3: a step without clear advances by exactly one
    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clr) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/exr_read_check.sv
module exr_read_check #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    output logic              mism,
    output logic [ADDR_W-1:0] mism_addr,
    output logic [DATA_W-1:0] actual
);
    logic              pend_v;
    logic [ADDR_W-1:0] pend_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= '0;
        end else begin
            pend_v    <= issue;
            pend_addr <= issue_addr;
        end
    end

    assign mism      = pend_v && (rdata != expected);
    assign mism_addr = pend_addr;
    assign actual    = rdata;

endmodule

// File: rtl/exr_ctrl.sv
module exr_ctrl
    import exr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] pattern_in,
    input  logic              module_sel,
    input  logic              cfg_8k,
    input  logic              adv_int,
    input  logic              cont_write,
    input  logic              exit_req,
    input  logic              at_end,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mism,
    input  logic [ADDR_W-1:0] mism_addr,
    input  logic [DATA_W-1:0] actual,
    output logic              sweep_clr,
    output logic              sweep_step,
    output logic              rd_issue,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_mod,
    output logic [DATA_W-1:0] pattern,
    output logic [1:0]        mode,
    output logic [PASS_W-1:0] pass_count,
    output logic              err_valid,
    output logic              err_module,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_actual,
    output logic [DATA_W-1:0] err_expected,
    output logic              cont_mismatch
);
    typedef struct packed {
        logic [DATA_W-1:0] pattern;
        logic              two_mod;
        logic              module_id;
    } run_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              module_id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] actual;
        logic [DATA_W-1:0] expected;
    } err_rec_t;

    mode_e             mode_q;
    vphase_e           vph_q;
    cphase_e           cph_q;
    run_cfg_t          cfg_q;
    err_rec_t          err_q;
    logic [PASS_W-1:0] pass_q;
    logic              sticky_q;

    logic in_verify, in_cont, escalate;

    assign in_verify = (mode_q == MODE_VERIFY);
    assign in_cont   = (mode_q == MODE_CONT);
    assign escalate  = in_verify && adv_int && !exit_req && !mism;

    always_comb begin
        mem_en = (in_verify && vph_q != VP_DRAIN) || in_cont;
        mem_we = (in_verify && vph_q == VP_WRITE) || (in_cont && cph_q != CP_READ);
    end

    assign rd_issue   = mem_en && !mem_we;
    assign sweep_step = mem_en;
    assign sweep_clr  = (mode_q == MODE_IDLE) || escalate;
    assign mem_mod    = cfg_q.module_id;
    assign pattern    = cfg_q.pattern;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_IDLE;
            vph_q    <= VP_WRITE;
            cph_q    <= CP_WRITE;
            cfg_q    <= '0;
            err_q    <= '0;
            pass_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            unique case (mode_q)
                MODE_IDLE: begin
                    if (start) begin
                        cfg_q.pattern   <= pattern_in;
                        cfg_q.two_mod   <= cfg_8k;
                        cfg_q.module_id <= pick_module(cfg_8k, module_sel);
                        mode_q          <= MODE_VERIFY;
                        vph_q           <= VP_WRITE;
                        pass_q          <= '0;
                        err_q           <= '0;
                        sticky_q        <= 1'b0;
                    end
                end
                MODE_VERIFY: begin
                    if (exit_req) begin
                        mode_q <= MODE_IDLE;
                    end else if (mism) begin
                        mode_q          <= MODE_FAIL;
                        err_q.valid     <= 1'b1;
                        err_q.module_id <= cfg_q.module_id;
                        err_q.addr      <= mism_addr;
                        err_q.actual    <= actual;
                        err_q.expected  <= cfg_q.pattern;
                    end else if (adv_int) begin
                        mode_q <= MODE_CONT;
                        cph_q  <= cont_write ? CP_WRITE : CP_FILL;
                    end else begin
                        unique case (vph_q)
                            VP_WRITE: if (at_end) vph_q <= VP_READ;
                            VP_READ:  if (at_end) vph_q <= VP_DRAIN;
                            default: begin
                                vph_q  <= VP_WRITE;
                                pass_q <= pass_q + 1'b1;
                            end
                        endcase
                    end
                end
                MODE_CONT: begin
                    if (exit_req) begin
                        mode_q <= MODE_IDLE;
                    end else begin
                        if (mism && cph_q == CP_READ)
                            sticky_q <= 1'b1;
                        if (cph_q == CP_FILL && at_end)
                            cph_q <= CP_READ;
                    end
                end
                default: begin
                    if (exit_req)
                        mode_q <= MODE_IDLE;
                end
            endcase
        end
    end

    assign mode          = mode_q;
    assign pass_count    = pass_q;
    assign err_valid     = err_q.valid;
    assign err_module    = err_q.module_id;
    assign err_addr      = err_q.addr;
    assign err_actual    = err_q.actual;
    assign err_expected  = err_q.expected;
    assign cont_mismatch = sticky_q;

    // R5: a failed run stays failed until exit
    assert_fail_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FAIL && !exit_req) |=> (mode_q == MODE_FAIL));

    // R5: a failed run issues no access
    assert_fail_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FAIL) |-> !mem_en);

    // R5: the captured report reflects a real difference seen by the checker
    assert_err_differs_R5: assert property (@(posedge clk) disable iff (rst)
        (in_verify && mism && !exit_req) |=> (mode_q == MODE_FAIL && err_actual != err_expected));

    // R4: outside a start, the pass count holds or rises by one
    assert_pass_step_R4: assert property (@(posedge clk) disable iff (rst)
        !(mode_q == MODE_IDLE && start) |=>
            (pass_q == $past(pass_q) || pass_q == $past(pass_q) + 1'b1));

    // R2: single-module configuration never addresses module 1
    assert_mod_single_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !cfg_q.two_mod) |-> (mem_mod == 1'b0));

    // R6: continuous mode is reachable only from verify
    assert_no_cont_from_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_VERIFY && mode_q != MODE_CONT) |=> (mode_q != MODE_CONT));

    // R8: once reading in continuous mode, no write follows while it lasts
    assert_cont_read_stays_R8: assert property (@(posedge clk) disable iff (rst)
        (in_cont && cph_q == CP_READ && !exit_req) |=> (in_cont && !mem_we));

    // R9: exit returns to idle on that edge
    assert_exit_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (exit_req && mode_q != MODE_IDLE) |=> (mode_q == MODE_IDLE && !mem_en));

    // R10: the reset state holds on the edge after reset
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_IDLE && pass_q == '0 && !err_q.valid && !sticky_q));

endmodule

// File: rtl/pattern_exerciser.sv
module pattern_exerciser #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int PASS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] pattern_in,
    input  logic              module_sel,
    input  logic              cfg_8k,
    input  logic              adv_int,
    input  logic              cont_write,
    input  logic              exit_req,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_mod,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        mode,
    output logic [PASS_W-1:0] pass_count,
    output logic              err_valid,
    output logic              err_module,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_actual,
    output logic [DATA_W-1:0] err_expected,
    output logic              cont_mismatch
);
    logic              sweep_clr, sweep_step, at_end, rd_issue, mism;
    logic [ADDR_W-1:0] addr, mism_addr;
    logic [DATA_W-1:0] pattern, actual;

    exr_addr_sweep #(.ADDR_W(ADDR_W)) u_sweep (
        .clk    (clk),
        .rst    (rst),
        .clr    (sweep_clr),
        .step   (sweep_step),
        .addr   (addr),
        .at_end (at_end)
    );

    exr_read_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_check (
        .clk        (clk),
        .rst        (rst),
        .issue      (rd_issue),
        .issue_addr (addr),
        .rdata      (mem_rdata),
        .expected   (pattern),
        .mism       (mism),
        .mism_addr  (mism_addr),
        .actual     (actual)
    );

    exr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PASS_W(PASS_W)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .pattern_in    (pattern_in),
        .module_sel    (module_sel),
        .cfg_8k        (cfg_8k),
        .adv_int       (adv_int),
        .cont_write    (cont_write),
        .exit_req      (exit_req),
        .at_end        (at_end),
        .addr          (addr),
        .mism          (mism),
        .mism_addr     (mism_addr),
        .actual        (actual),
        .sweep_clr     (sweep_clr),
        .sweep_step    (sweep_step),
        .rd_issue      (rd_issue),
        .mem_en        (mem_en),
        .mem_we        (mem_we),
        .mem_mod       (mem_mod),
        .pattern       (pattern),
        .mode          (mode),
        .pass_count    (pass_count),
        .err_valid     (err_valid),
        .err_module    (err_module),
        .err_addr      (err_addr),
        .err_actual    (err_actual),
        .err_expected  (err_expected),
        .cont_mismatch (cont_mismatch)
    );

    assign mem_addr  = addr;
    assign mem_wdata = pattern;

endmodule

// File: tb/sim_pattern_exerciser.sv
`timescale 1ns/1ps
module sim_pattern_exerciser;
    localparam int DW = 16;
    localparam int AW = 4;
    localparam int PW = 16;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, module_sel = 0, cfg_8k = 0, adv_int = 0, cont_write = 0, exit_req = 0;
    logic [DW-1:0] pattern_in = '0;
    logic mem_en, mem_we, mem_mod;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [1:0] mode;
    logic [PW-1:0] pass_count;
    logic err_valid, err_module, cont_mismatch;
    logic [AW-1:0] err_addr;
    logic [DW-1:0] err_actual, err_expected;

    always #5 clk = ~clk;

    pattern_exerciser #(.DATA_W(DW), .ADDR_W(AW), .PASS_W(PW)) u0 (
        .clk(clk), .rst(rst), .start(start), .pattern_in(pattern_in),
        .module_sel(module_sel), .cfg_8k(cfg_8k), .adv_int(adv_int),
        .cont_write(cont_write), .exit_req(exit_req),
        .mem_en(mem_en), .mem_we(mem_we), .mem_mod(mem_mod), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mode(mode),
        .pass_count(pass_count), .err_valid(err_valid), .err_module(err_module),
        .err_addr(err_addr), .err_actual(err_actual), .err_expected(err_expected),
        .cont_mismatch(cont_mismatch)
    );

    // Memory model with one injectable faulty word, plus access monitor
    logic [DW-1:0] mem0 [N];
    logic [DW-1:0] mem1 [N];
    logic          flt_en = 0, flt_mod = 0, exp_mod = 0;
    logic [AW-1:0] flt_addr = '0;
    logic [DW-1:0] flt_mask = '0;
    int wr_cnt = 0, rd_cnt = 0, mod_bad = 0, order_bad = 0;
    logic prev_acc = 0;
    logic [AW-1:0] prev_addr = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_mod != exp_mod) mod_bad++;
            if (prev_acc && mem_addr != AW'(prev_addr + 1) && mem_addr != '0) order_bad++;
            if (mem_we) begin
                wr_cnt++;
                if (mem_mod) mem1[mem_addr] <= mem_wdata;
                else         mem0[mem_addr] <= mem_wdata;
            end else begin
                rd_cnt++;
                mem_rdata <= (mem_mod ? mem1[mem_addr] : mem0[mem_addr]) ^
                             ((flt_en && flt_mod == mem_mod && flt_addr == mem_addr) ? flt_mask : '0);
            end
        end
        prev_acc  <= mem_en;
        prev_addr <= mem_addr;
    end

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input logic [DW-1:0] p, input logic big, input logic sel);
        pattern_in = p; cfg_8k = big; module_sel = sel; exp_mod = big & sel;
        start = 1'b1;
        cycles(1);
        start = 1'b0;
    endtask

    task automatic do_exit();
        exit_req = 1'b1;
        cycles(1);
        exit_req = 1'b0;
    endtask

    task automatic wait_pass(input int target, input int limit);
        for (int i = 0; i < limit; i++) begin
            if (pass_count >= PW'(target)) break;
            cycles(1);
        end
    endtask

    int wr0, rd0, cyc, bad;

    initial begin
        for (int i = 0; i < N; i++) begin mem0[i] = '0; mem1[i] = '0; end
        @(negedge clk);
        cycles(3);
        rst = 1'b0;
        cycles(1);
        // R10 reset state
        chk(mode == 2'd0 && !mem_en && pass_count == 0 && !err_valid && !cont_mismatch,
            "R10 reset state", {mode, mem_en, err_valid, cont_mismatch}, 0);

        // Verify on single-module config with module_sel=1 (R1 R2 R3 R4)
        wr0 = wr_cnt; rd0 = rd_cnt;
        pattern_in = 16'h5A3C; cfg_8k = 0; module_sel = 1; exp_mod = 0;
        start = 1'b1;
        cyc = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (i == 0) begin start = 1'b0; pattern_in = 16'hFFFF; module_sel = 0; end
            if (pass_count == 1) break;
        end
        chk(cyc == 2*N + 2, "R4 first pass timing", cyc, 2*N + 2);
        chk(wr_cnt - wr0 == N, "R3 writes per sweep", wr_cnt - wr0, N);
        chk(rd_cnt - rd0 == N, "R3 reads per sweep", rd_cnt - rd0, N);
        bad = 0;
        for (int i = 0; i < N; i++) if (mem0[i] != 16'h5A3C) bad++;
        chk(bad == 0, "R1 latched pattern in memory", bad, 0);
        wait_pass(3, 400);
        chk(pass_count == 3 && mode == 2'd1, "R4 repeated sweeps", pass_count, 3);
        chk(mod_bad == 0, "R2 single config uses module 0", mod_bad, 0);
        chk(order_bad == 0, "R3 ascending addresses", order_bad, 0);
        do_exit();
        chk(mode == 2'd0 && !mem_en, "R9 exit to idle", mode, 0);
        wr0 = wr_cnt; rd0 = rd_cnt;
        cycles(10);
        chk(wr_cnt == wr0 && rd_cnt == rd0, "R9 idle quiet", wr_cnt + rd_cnt, wr0 + rd0);

        // Mismatch in module 1 (R5)
        flt_en = 1; flt_mod = 1; flt_addr = 4'd9; flt_mask = 16'h0100;
        do_start(16'hAAAA, 1'b1, 1'b1);
        for (int i = 0; i < 200; i++) begin
            if (mode == 2'd3) break;
            cycles(1);
        end
        chk(mode == 2'd3 && err_valid, "R5 stop on mismatch", mode, 3);
        chk(err_module == 1'b1, "R5 err module", err_module, 1);
        chk(err_addr == 4'd9, "R5 err addr", err_addr, 9);
        chk(err_actual == 16'hABAA, "R5 err actual", err_actual, 16'hABAA);
        chk(err_expected == 16'hAAAA, "R5 err expected", err_expected, 16'hAAAA);
        chk(pass_count == 0, "R5 no pass counted", pass_count, 0);
        wr0 = wr_cnt; rd0 = rd_cnt;
        adv_int = 1'b1; cont_write = 1'b1;
        cycles(3);
        adv_int = 1'b0;
        cycles(15);
        chk(wr_cnt == wr0 && rd_cnt == rd0, "R5 no access after fail", wr_cnt + rd_cnt, wr0 + rd0);
        chk(mode == 2'd3, "R6 adv_int ignored when failed", mode, 3);
        do_exit();
        chk(err_valid && err_addr == 4'd9, "R9 error kept after exit", err_addr, 9);
        adv_int = 1'b1;
        cycles(2);
        adv_int = 1'b0;
        chk(mode == 2'd0, "R6 adv_int ignored when idle", mode, 0);

        // Module 0 selected in two-module config, fault left on module 1 (R2)
        mod_bad = 0;
        do_start(16'h00FF, 1'b1, 1'b0);
        chk(!err_valid, "R9 error cleared at start", err_valid, 0);
        wait_pass(2, 400);
        chk(pass_count == 2 && mode == 2'd1 && mod_bad == 0, "R2 module 0 chosen",
            {pass_count, mod_bad[7:0]}, 16'h0200);
        do_exit();
        flt_en = 0;

        // Continuous write (R6 R7)
        order_bad = 0;
        do_start(16'h1234, 1'b1, 1'b1);
        cycles(7);
        adv_int = 1'b1; cont_write = 1'b1;
        @(posedge clk); @(negedge clk);
        adv_int = 1'b0; cont_write = 1'b0;
        chk(mode == 2'd2, "R6 advance to continuous", mode, 2);
        wr0 = wr_cnt; rd0 = rd_cnt;
        cycles(3*N);
        chk(wr_cnt - wr0 == 3*N && rd_cnt == rd0, "R7 writes only", rd_cnt - rd0, 0);
        chk(order_bad == 0 && mod_bad == 0, "R7 wrapping addresses", order_bad, 0);
        bad = 0;
        for (int i = 0; i < N; i++) if (mem1[i] != 16'h1234) bad++;
        chk(bad == 0, "R7 memory holds pattern", bad, 0);
        do_exit();

        // Continuous read (R8)
        do_start(16'h0F0F, 1'b0, 1'b1);
        cycles(5);
        adv_int = 1'b1; cont_write = 1'b0;
        @(posedge clk); @(negedge clk);
        adv_int = 1'b0;
        wr0 = wr_cnt; rd0 = rd_cnt;
        cycles(N);
        chk(wr_cnt - wr0 == N && rd_cnt == rd0, "R8 single fill sweep", wr_cnt - wr0, N);
        wr0 = wr_cnt; rd0 = rd_cnt;
        cycles(2*N);
        chk(rd_cnt - rd0 == 2*N && wr_cnt == wr0, "R8 reads only after fill", rd_cnt - rd0, 2*N);
        chk(!cont_mismatch, "R8 no false mismatch", cont_mismatch, 0);
        flt_en = 1; flt_mod = 0; flt_addr = 4'd3; flt_mask = 16'h0001;
        cycles(N + 2);
        flt_en = 0;
        cycles(N + 2);
        chk(cont_mismatch && mode == 2'd2, "R8 sticky flag, keeps running", {cont_mismatch, mode}, 3'b110);
        chk(order_bad == 0 && mod_bad == 0, "R8 addresses and module", order_bad + mod_bad, 0);
        do_exit();
        chk(mode == 2'd0, "R9 exit from continuous", mode, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule